// File: doc/BRIEF.md
# One-Time Programmable Word Memory Model

This block is a clocked, synthesizable stand-in for a word-wide one-time programmable read-only memory with a parallel pin-style interface. It is driven by a word address, a data-in word, three active-low strobes (chip select, output gate and program pulse), and two digital flags. One flag says that the high programming supply is present. The other says that the high-voltage level is applied to address bit 9. From these inputs the block works out whether it is reading, verifying, programming, inhibited, idle or returning its identification words. It presents a data word together with a drive-enable flag that stands for the tri-state pins.

Every cell starts out erased, with all ones. A program operation can only turn ones into zeros. Access delays are whole clock cycles set by parameters. The array depth is a parameter too: a production build sets it to the full 16-bit address space, while the default stays small for simulation.

Top module: `otp_word_store`

## Requirements
- R1: After reset every word reads 16'hFFFF and `dout_en` is low until an access has settled.
- R2: With `ce_n` low and `oe_n` low, the word at array index `addr[ARR_AW-1:0]` is driven once settled. Higher address bits do not select a different word. `pgm_n` has no effect on a read.
- R3: While `ce_n` or `oe_n` is high, `dout_en` is low and `dout` is 16'h0000 in the same cycle, with no clock edge needed.
- R4: A program pulse requires `ce_n` low, `oe_n` high, `pgm_n` low and `vpp_hi` high. When the pulse ends, the addressed word becomes its old value AND `din`, so a zero bit never returns to one.
- R5: A program pulse that is sampled low on fewer than PGM_MIN clock edges leaves the array unchanged.
- R6: No write happens when `vpp_hi` is low, when `ce_n` is high (inhibit) or when `oe_n` is low, whatever `pgm_n` does. During inhibit the outputs float.
- R7: With `vpp_hi` high, `ce_n` low, `oe_n` low and `pgm_n` high (verify), the stored word is driven.
- R8: When `a9_hv` is high and `addr[15:1]` is zero, the output is 16'h001E for `addr[0]`=0 and 16'h00F1 for `addr[0]`=1. With any of `addr[15:1]` set, array data is returned.
- R9: A change of `addr` or `a9_hv`, or a fall of `ce_n`, first sampled at edge k, keeps `dout_en` low until edge k+T_ACC. Data is driven from that edge on.
- R10: A fall of `oe_n` first sampled at edge j keeps `dout_en` low until edge j+T_OE. Lowering `oe_n` up to T_ACC-T_OE edges after the address change does not delay the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset; erases the array |
| addr | input | 16 | Word address |
| din | input | 16 | Word to program |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program pulse |
| vpp_hi | input | 1 | Programming supply present |
| a9_hv | input | 1 | High voltage on address bit 9 |
| dout | output | 16 | Data word, zero while not driven |
| dout_en | output | 1 | Pins driven (low means high impedance) |

## Verification
The assertions assume that inputs change only between clock edges, and that address and data stay steady for the whole of a program pulse. They also assume the configuration keeps T_ACC at least 1 and T_OE no larger than T_ACC, so that the settle checks on address, select and gate edges are meaningful. The stimulus changes every input on the falling clock edge and never touches address or data while `pgm_n` is low. Each read begins by deselecting the chip for one cycle, so that every access starts with a fresh select edge.

// File: rtl/otp_word_store.sv
module otp_word_store #(
  parameter int DW       = 16,
  parameter int AW       = 16,
  parameter int ARR_AW   = 8,
  parameter int T_ACC    = 4,
  parameter int T_OE     = 2,
  parameter int PGM_MIN  = 3,
  parameter logic [DW-1:0] MFR_CODE = 'h001E,
  parameter logic [DW-1:0] DEV_CODE = 'h00F1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic          vpp_hi,
  input  logic          a9_hv,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  localparam int DEPTH = 1 << ARR_AW;
  localparam int ACW   = $clog2(T_ACC + 1);
  localparam int OCW   = $clog2(T_OE + 1);
  localparam int PCW   = $clog2(PGM_MIN + 1);
  localparam logic [ACW-1:0] ACC_TOP = ACW'(T_ACC);
  localparam logic [OCW-1:0] OE_TOP  = OCW'(T_OE);
  localparam logic [PCW-1:0] PGM_TOP = PCW'(PGM_MIN);

  logic [DW-1:0]     cells [DEPTH];
  logic [AW-1:0]     addr_q;
  logic              a9_q, ce_qn, oe_qn;
  logic [ACW-1:0]    acc_cnt;
  logic [OCW-1:0]    oe_cnt;
  logic              prg_q;
  logic [PCW-1:0]    pcnt;
  logic [ARR_AW-1:0] pa_q;
  logic [DW-1:0]     pd_q;

  wire prog_mode  = !ce_n && oe_n && !pgm_n && vpp_hi;
  wire wr_go      = prg_q && !prog_mode && (pcnt == PGM_TOP);
  wire addr_moved = (addr != addr_q) || (a9_hv != a9_q);
  wire id_sel     = a9_hv && (addr[AW-1:1] == '0);
  wire settled    = !addr_moved && (acc_cnt == ACC_TOP) && (oe_cnt == OE_TOP);
  wire [DW-1:0] word = id_sel ? (addr[0] ? DEV_CODE : MFR_CODE)
                              : cells[addr[ARR_AW-1:0]];

  assign dout_en = !ce_n && !oe_n && settled;
  assign dout    = dout_en ? word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      a9_q    <= 1'b0;
      ce_qn   <= 1'b1;
      oe_qn   <= 1'b1;
      acc_cnt <= '0;
      oe_cnt  <= '0;
    end else begin
      addr_q <= addr;
      a9_q   <= a9_hv;
      ce_qn  <= ce_n;
      oe_qn  <= oe_n;
      if (ce_n || ce_qn || addr_moved) acc_cnt <= '0;
      else if (acc_cnt != ACC_TOP)     acc_cnt <= acc_cnt + 1'b1;
      if (oe_n || oe_qn)               oe_cnt <= '0;
      else if (oe_cnt != OE_TOP)       oe_cnt <= oe_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_q <= 1'b0;
      pcnt  <= '0;
      pa_q  <= '0;
      pd_q  <= '0;
    end else if (prog_mode) begin
      prg_q <= 1'b1;
      pa_q  <= addr[ARR_AW-1:0];
      pd_q  <= din;
      if (pcnt != PGM_TOP) pcnt <= pcnt + 1'b1;
    end else begin
      prg_q <= 1'b0;
      pcnt  <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_go) begin
      cells[pa_q] <= cells[pa_q] & pd_q;
    end
  end
endmodule

// File: rtl/otp_word_store_chk.sv
module otp_word_store_chk #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          ce_n,
  input logic          oe_n,
  input logic          vpp_hi,
  input logic          a9_hv,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic          wr_go
);
  a_r3_float_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !dout_en);
  a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));
  a_r9_addr_settle: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr != $past(addr)) || (a9_hv != $past(a9_hv))) |-> !dout_en);
  a_r9_ce_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> !dout_en);
  a_r10_oe_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !dout_en);
  a_r6_write_guard: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> $past(!ce_n && oe_n && vpp_hi));
endmodule

bind otp_word_store otp_word_store_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .vpp_hi(vpp_hi), .a9_hv(a9_hv), .dout(dout), .dout_en(dout_en),
  .wr_go(wr_go)
);

// File: tb/sim_otp_word_store.sv
`timescale 1ns/1ps
module sim_otp_word_store;
  localparam int T_ACC = 4;
  localparam int T_OE = 2;
  localparam int PGM_MIN = 3;
  localparam int ARR_AW = 8;
  localparam int DEPTH = 1 << ARR_AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [15:0] addr = '0, din = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0;
  logic [15:0] dout;
  logic dout_en;

  otp_word_store #(.DW(16), .AW(16), .ARR_AW(ARR_AW), .T_ACC(T_ACC),
                   .T_OE(T_OE), .PGM_MIN(PGM_MIN)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi), .a9_hv(a9_hv),
    .dout(dout), .dout_en(dout_en));

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] model [DEPTH];

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic read_chk(input logic [15:0] a, input logic [15:0] exp,
                          input string req);
    @(negedge clk) ce_n = 1'b1;
    @(negedge clk) begin addr = a; ce_n = 1'b0; oe_n = 1'b0; end
    repeat (T_ACC) @(posedge clk);
    @(negedge clk) chk(dout_en == 1'b0, "R9 early", {15'd0, dout_en}, 16'd0);
    @(posedge clk);
    @(negedge clk) chk(dout_en == 1'b1 && dout == exp, req, dout, exp);
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d, input int n);
    @(negedge clk) begin
      ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b1; a9_hv = 1'b0;
      addr = a; din = d; pgm_n = 1'b0;
    end
    repeat (n) @(posedge clk);
    @(negedge clk) pgm_n = 1'b1;
    @(negedge clk) begin vpp_hi = 1'b0; ce_n = 1'b1; end
    if (n >= PGM_MIN) model[a[ARR_AW-1:0]] &= d;
  endtask

  task automatic try_write(input logic [15:0] a, input logic c, input logic o,
                           input logic v);
    @(negedge clk) begin
      ce_n = c; oe_n = o; vpp_hi = v; addr = a; din = 16'h0000; pgm_n = 1'b0;
    end
    repeat (PGM_MIN + 2) @(posedge clk);
    @(negedge clk) begin
      if (c) chk(dout_en == 1'b0, "R6 inhibit float", {15'd0, dout_en}, 16'd0);
      pgm_n = 1'b1;
    end
    @(negedge clk) begin vpp_hi = 1'b0; ce_n = 1'b1; oe_n = 1'b1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk) begin ce_n = 1'b0; oe_n = 1'b0; end
    #1 chk(dout_en == 1'b0 && dout == 16'h0, "R1 reset idle", dout, 16'h0);

    for (int a = 0; a < DEPTH; a++) read_chk(16'(a), 16'hFFFF, "R1 erased");

    for (int a = 0; a < DEPTH; a++) prog(16'(a), 16'(a * 16'h9E37) ^ 16'h5A5A, PGM_MIN);
    for (int a = 0; a < DEPTH; a++) read_chk(16'(a), model[a], "R4 first pass");

    for (int a = 0; a < DEPTH; a++) prog(16'(a), 16'(a * 16'h3C6F + 16'h1234), PGM_MIN + 1);
    for (int a = 0; a < DEPTH; a++) read_chk(16'(a), model[a], "R4 sticky zeros");

    for (int a = 0; a < 32; a++) prog(16'(a), 16'h0000, PGM_MIN - 1);
    for (int a = 0; a < 32; a++) read_chk(16'(a), model[a], "R5 short pulse");

    try_write(16'd40, 1'b0, 1'b1, 1'b0);
    try_write(16'd41, 1'b1, 1'b1, 1'b1);
    try_write(16'd42, 1'b0, 1'b0, 1'b1);
    read_chk(16'd40, model[40], "R6 no supply");
    read_chk(16'd41, model[41], "R6 inhibit");
    read_chk(16'd42, model[42], "R6 gate low");

    @(negedge clk) pgm_n = 1'b0;
    read_chk(16'd7, model[7], "R2 strobe ignored");
    @(negedge clk) pgm_n = 1'b1;
    read_chk(16'h0105, model[5], "R2 upper bits alias");

    @(negedge clk) vpp_hi = 1'b1;
    for (int a = 100; a < 116; a++) read_chk(16'(a), model[a], "R7 verify");
    @(negedge clk) vpp_hi = 1'b0;

    @(negedge clk) a9_hv = 1'b1;
    read_chk(16'h0000, 16'h001E, "R8 maker code");
    read_chk(16'h0001, 16'h00F1, "R8 device code");
    read_chk(16'h0002, model[2], "R8 no id");
    read_chk(16'h0100, model[0], "R8 high bit");
    @(negedge clk) a9_hv = 1'b0;

    read_chk(16'd9, model[9], "R3 setup");
    @(negedge clk) oe_n = 1'b1;
    #1 chk(dout_en == 1'b0 && dout == 16'h0, "R3 gate high", dout, 16'h0);
    @(negedge clk) begin oe_n = 1'b0; ce_n = 1'b1; end
    #1 chk(dout_en == 1'b0 && dout == 16'h0, "R3 select high", dout, 16'h0);

    @(negedge clk) begin ce_n = 1'b0; oe_n = 1'b1; addr = 16'd20; end
    repeat (T_ACC - T_OE) @(posedge clk);
    @(negedge clk) oe_n = 1'b0;
    repeat (T_OE) @(posedge clk);
    @(negedge clk) chk(dout_en == 1'b0, "R10 late gate early", {15'd0, dout_en}, 16'd0);
    @(posedge clk);
    @(negedge clk) chk(dout_en && dout == model[20], "R10 late gate", dout, model[20]);

    @(negedge clk) oe_n = 1'b1;
    @(negedge clk) oe_n = 1'b0;
    repeat (T_OE) @(posedge clk);
    @(negedge clk) chk(dout_en == 1'b0, "R10 gate delay early", {15'd0, dout_en}, 16'd0);
    @(posedge clk);
    @(negedge clk) chk(dout_en && dout == model[20], "R10 gate delay", dout, model[20]);

    @(negedge clk) addr = 16'd21;
    repeat (T_ACC) @(posedge clk);
    @(negedge clk) chk(dout_en == 1'b0, "R9 address move early", {15'd0, dout_en}, 16'd0);
    @(posedge clk);
    @(negedge clk) chk(dout_en && dout == model[21], "R9 address move", dout, model[21]);

    finish_up();
  end
endmodule